// File: doc/BRIEF.md
# Indexed Colour Palette with Per-Channel Gamma

This block turns an 8-bit colour index and a palette number into a 24-bit RGB pixel. The palette memory is split into banks, one per palette number. Every entry is four bytes: blue, green, red and an alpha byte. The alpha byte is kept only for software. After the palette lookup, each colour channel can be remapped through its own 256-entry gamma table. One bit of the mode byte switches this stage in or out.

Two ports reach the memories. A byte-wide CPU port writes and reads any palette byte or gamma byte through a flat 14-bit byte address. A pixel port takes one index per clock and returns the colour after a fixed two-clock pipeline. The two ports work in the same cycles and never stall each other.

Index 0 means transparent. It yields black with the output valid low, whatever the palette holds at entry 0. Palette numbers above the implemented banks decode as holes: they read as zero and ignore writes.

Top module: `pgx_palette_gamma`

## Requirements
- R1: While reset is high and after it is released, before any pixel is issued, `out_valid` is 0, `out_rgb` is 0 and `cpu_rdata` is 0.
- R2: With `cpu_addr[13]`=0, the address selects a palette byte. `cpu_addr[12:10]` is the palette number, `cpu_addr[9:2]` is the entry and `cpu_addr[1:0]` is the byte lane (0 blue, 1 green, 2 red, 3 alpha). A write with `cpu_wr` high stores `cpu_wdata`. `cpu_rdata` shows the byte at the address presented in the previous cycle.
- R3: The alpha byte (lane 3) reads back what was written to it. It has no effect on `out_rgb` or `out_valid`.
- R4: A pixel with `pix_valid`=1 and a nonzero `pix_index` produces `out_valid`=1 exactly two rising edges later. The colour is `out_rgb` = {red, green, blue}, with red in [23:16], green in [15:8] and blue in [7:0]. It is taken from entry `pix_index` of palette `pix_slot`. A new pixel is accepted on every clock.
- R5: A pixel with `pix_valid`=0 or `pix_index`=0 gives `out_valid`=0 and `out_rgb`=0 two edges later, whatever entry 0 holds.
- R6: Palette numbers 4 to 7 are not implemented. CPU writes to them change nothing and CPU reads of them return 0x00. A valid pixel with a nonzero index from such a palette has `out_valid`=1, and its colour before gamma is 0x000000.
- R7: With `cpu_addr[13]`=1 and `cpu_addr[12:10]`=0, the address selects a gamma byte. `cpu_addr[9:8]` is the channel (0 blue, 1 green, 2 red) and `cpu_addr[7:0]` is the table entry. Channel 3, or any nonzero `cpu_addr[12:10]`, is a hole: it reads 0x00 and writes to it are dropped.
- R8: When `mode_ctrl[6]` is 1 in the cycle a pixel enters, each of its channels is replaced by that channel's gamma table entry at the raw value. When the bit is 0, the raw palette colour is output. The latency is two edges in both cases.
- R9: A CPU write and a pixel lookup of the same palette entry in the same cycle give the pixel the value held before the write. A pixel issued in the next cycle sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the pipeline and read-select state |
| mode_ctrl | input | 8 | Mode byte; bit 6 enables gamma remapping |
| cpu_wr | input | 1 | CPU byte write strobe |
| cpu_addr | input | 14 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data for the address of the previous cycle |
| pix_valid | input | 1 | Pixel request valid |
| pix_index | input | 8 | Colour index, 0 = transparent |
| pix_slot | input | 3 | Palette number |
| out_valid | output | 1 | Pixel result valid, two clocks after request |
| out_rgb | output | 24 | Pixel colour {red, green, blue} |

## Verification
The CPU write port and the pixel read port can address the same palette entry on the same clock edge. That collision is the case that decides whether the display shows stale or fresh colour. The bench provokes it by driving a red-lane write and a pixel lookup of that entry in one cycle, then repeating the same lookup in the next cycle. It judges the two results two edges later: the first must carry the old red byte and the second the new one. A concurrent CPU read of the same byte is also checked against the old-then-new rule.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    localparam int CH_W     = 8;                 // bits per colour channel
    localparam int IDX_W    = 8;                 // colour index width
    localparam int SLOT_W   = 3;                 // palette number width
    localparam int LANE_W   = 2;                 // byte lane select width
    localparam int SLOT_LSB = IDX_W + LANE_W;    // palette number position in the address
    localparam int ADDR_W   = SLOT_LSB + SLOT_W + 1;
    localparam int N_CH     = 3;                 // blue, green, red
    localparam int TBL_D    = 1 << IDX_W;        // entries per palette / gamma table

    typedef enum logic [LANE_W-1:0] {
        LANE_B = 2'd0,
        LANE_G = 2'd1,
        LANE_R = 2'd2,
        LANE_A = 2'd3
    } lane_e;

    typedef struct packed {
        logic              pal_hit;
        logic              gam_hit;
        logic [SLOT_W-1:0] slot;
        logic [IDX_W-1:0]  entry;
        lane_e             lane;
    } cpu_tgt_t;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    // Decode a CPU byte address into a palette or gamma target.
    function automatic cpu_tgt_t decode_cpu(input logic [ADDR_W-1:0] a, input int banks);
        cpu_tgt_t t;
        t = '0;
        if (!a[ADDR_W-1]) begin
            t.slot    = a[SLOT_LSB +: SLOT_W];
            t.entry   = a[LANE_W +: IDX_W];
            t.lane    = lane_e'(a[LANE_W-1:0]);
            t.pal_hit = int'(t.slot) < banks;
        end else begin
            t.entry   = a[IDX_W-1:0];
            t.lane    = lane_e'(a[IDX_W +: LANE_W]);
            t.gam_hit = (a[SLOT_LSB +: SLOT_W] == '0) && (t.lane != LANE_A);
        end
        return t;
    endfunction

endpackage

// File: rtl/pgx_lane_ram.sv
// One byte lane of storage: CPU read/write port plus an independent pixel read port.
// Both reads are registered and return the contents held before a same-edge write.
module pgx_lane_ram #(
    parameter int DW    = 8,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cpu_q,
    input  logic [AW-1:0] pix_addr,
    output logic [DW-1:0] pix_q
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[cpu_addr] <= wdata;
        end
        cpu_q <= mem[cpu_addr];
        pix_q <= mem[pix_addr];
    end

    // R9: a colliding pixel read sees the contents from before the write
    p_rdw_old_r9: assert property (@(posedge clk) disable iff (rst)
        (we && pix_addr == cpu_addr) |=> (pix_q == $past(mem[cpu_addr])));

    // R9: the written byte is visible to the CPU port on the next access
    p_wr_visible_r9: assert property (@(posedge clk) disable iff (rst)
        we ##1 (cpu_addr == $past(cpu_addr)) |=> (cpu_q == $past(wdata, 2)));

endmodule

// File: rtl/pgx_spare_ram.sv
// CPU-only byte storage, used for the alpha lane that never reaches the pixel path.
module pgx_spare_ram #(
    parameter int DW    = 8,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        q <= mem[addr];
    end

endmodule

// File: rtl/pgx_palette_gamma.sv
module pgx_palette_gamma
    import pgx_pkg::*;
#(
    parameter int NUM_BANKS = 4      // implemented palettes, power of two, 2..8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        mode_ctrl,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [CH_W-1:0]   cpu_wdata,
    output logic [CH_W-1:0]   cpu_rdata,
    input  logic              pix_valid,
    input  logic [IDX_W-1:0]  pix_index,
    input  logic [SLOT_W-1:0] pix_slot,
    output logic              out_valid,
    output logic [3*CH_W-1:0] out_rgb
);

    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int PAL_DEPTH = NUM_BANKS * TBL_D;
    localparam int PAL_AW    = BANK_W + IDX_W;
    localparam int GAMMA_BIT = 6;

    // ---------------- CPU side decode ----------------
    cpu_tgt_t          tgt;
    cpu_tgt_t          rd_tgt;
    logic [PAL_AW-1:0] pal_cpu_addr;
    logic [N_CH-1:0]   pal_we;
    logic [N_CH-1:0]   gam_we;
    logic              alpha_we;

    always_comb begin
        tgt          = decode_cpu(cpu_addr, NUM_BANKS);
        pal_cpu_addr = {tgt.slot[BANK_W-1:0], tgt.entry};
        alpha_we     = cpu_wr && tgt.pal_hit && (tgt.lane == LANE_A);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_tgt <= '0;
        end else begin
            rd_tgt <= tgt;
        end
    end

    // ---------------- pixel stage 0 -> 1 ----------------
    logic              s1_valid;
    logic              s1_hole;
    logic              s1_gam;
    logic [PAL_AW-1:0] pal_pix_addr;
    logic [CH_W-1:0]   pal_cpu_q [N_CH];
    logic [CH_W-1:0]   pal_pix_q [N_CH];
    logic [CH_W-1:0]   gam_cpu_q [N_CH];
    logic [CH_W-1:0]   gam_pix_q [N_CH];
    logic [CH_W-1:0]   s1_ch     [N_CH];
    logic [CH_W-1:0]   alpha_q;

    assign pal_pix_addr = {pix_slot[BANK_W-1:0], pix_index};

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_hole  <= 1'b0;
            s1_gam   <= 1'b0;
        end else begin
            s1_valid <= pix_valid && (pix_index != '0);
            s1_hole  <= int'(pix_slot) >= NUM_BANKS;
            s1_gam   <= mode_ctrl[GAMMA_BIT];
        end
    end

    // ---------------- per-channel storage ----------------
    genvar ch;
    generate
        for (ch = 0; ch < N_CH; ch++) begin : g_chan
            assign pal_we[ch] = cpu_wr && tgt.pal_hit && (int'(tgt.lane) == ch);
            assign gam_we[ch] = cpu_wr && tgt.gam_hit && (int'(tgt.lane) == ch);

            pgx_lane_ram #(.DW(CH_W), .DEPTH(PAL_DEPTH)) u_pal (
                .clk      (clk),
                .rst      (rst),
                .we       (pal_we[ch]),
                .cpu_addr (pal_cpu_addr),
                .wdata    (cpu_wdata),
                .cpu_q    (pal_cpu_q[ch]),
                .pix_addr (pal_pix_addr),
                .pix_q    (pal_pix_q[ch])
            );

            // slots above the implemented range contribute black
            assign s1_ch[ch] = s1_hole ? '0 : pal_pix_q[ch];

            pgx_lane_ram #(.DW(CH_W), .DEPTH(TBL_D)) u_gam (
                .clk      (clk),
                .rst      (rst),
                .we       (gam_we[ch]),
                .cpu_addr (tgt.entry),
                .wdata    (cpu_wdata),
                .cpu_q    (gam_cpu_q[ch]),
                .pix_addr (s1_ch[ch]),
                .pix_q    (gam_pix_q[ch])
            );
        end
    endgenerate

    pgx_spare_ram #(.DW(CH_W), .DEPTH(PAL_DEPTH)) u_alpha (
        .clk   (clk),
        .we    (alpha_we),
        .addr  (pal_cpu_addr),
        .wdata (cpu_wdata),
        .q     (alpha_q)
    );

    // ---------------- pixel stage 1 -> 2 ----------------
    logic s2_valid;
    logic s2_gam;
    rgb_t s2_raw;
    rgb_t gam_rgb;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
            s2_gam   <= 1'b0;
            s2_raw   <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_gam   <= s1_gam;
            s2_raw   <= '{r: s1_ch[2], g: s1_ch[1], b: s1_ch[0]};
        end
    end

    assign gam_rgb   = '{r: gam_pix_q[2], g: gam_pix_q[1], b: gam_pix_q[0]};
    assign out_valid = s2_valid;
    assign out_rgb   = !s2_valid ? '0 : (s2_gam ? gam_rgb : s2_raw);

    // ---------------- CPU read mux ----------------
    always_comb begin
        cpu_rdata = '0;
        if (rd_tgt.pal_hit) begin
            unique case (rd_tgt.lane)
                LANE_B: cpu_rdata = pal_cpu_q[0];
                LANE_G: cpu_rdata = pal_cpu_q[1];
                LANE_R: cpu_rdata = pal_cpu_q[2];
                LANE_A: cpu_rdata = alpha_q;
            endcase
        end else if (rd_tgt.gam_hit) begin
            unique case (rd_tgt.lane)
                LANE_B:  cpu_rdata = gam_cpu_q[0];
                LANE_G:  cpu_rdata = gam_cpu_q[1];
                default: cpu_rdata = gam_cpu_q[2];
            endcase
        end
    end

    // ---------------- assertions ----------------
    // R4: an opaque valid request appears two edges later
    p_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 1) && !$past(rst, 2) && $past(pix_valid, 2) && $past(pix_index, 2) != '0)
        |-> out_valid);

    // R5: transparent or idle requests never produce output
    p_transparent_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(pix_valid, 2) || $past(pix_index, 2) == '0) |-> (!out_valid && out_rgb == '0));

    // R6: writes to unimplemented palettes reach no storage
    p_hole_write_r6: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !cpu_addr[ADDR_W-1] && int'(cpu_addr[SLOT_LSB +: SLOT_W]) >= NUM_BANKS)
        |-> (pal_we == '0 && !alpha_we));

    // R6: reads of unimplemented palettes return zero
    p_hole_read_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cpu_addr[ADDR_W-1]) &&
         int'($past(cpu_addr[SLOT_LSB +: SLOT_W])) >= NUM_BANKS) |-> (cpu_rdata == '0));

    // R7: gamma holes are never written
    p_gam_hole_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[ADDR_W-1] &&
         (cpu_addr[IDX_W +: LANE_W] == 2'd3 || cpu_addr[SLOT_LSB +: SLOT_W] != '0))
        |-> (gam_we == '0));

endmodule

// File: tb/pgx_palette_gamma_test.sv
module pgx_palette_gamma_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mode_ctrl = '0;
    logic        cpu_wr = 1'b0;
    logic [13:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        pix_valid = 1'b0;
    logic [7:0]  pix_index = '0;
    logic [2:0]  pix_slot = '0;
    logic        out_valid;
    logic [23:0] out_rgb;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pgx_palette_gamma uut (
        .clk(clk), .rst(rst), .mode_ctrl(mode_ctrl),
        .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .pix_valid(pix_valid), .pix_index(pix_index), .pix_slot(pix_slot),
        .out_valid(out_valid), .out_rgb(out_rgb)
    );

    // ---------- reference contents ----------
    function automatic logic [7:0] pcol(input int bank, input int idx, input int lane);
        return 8'(idx * 7 + bank * 53 + lane * 91 + 3);
    endfunction

    function automatic logic [7:0] gmap(input int ch, input logic [7:0] v);
        return v ^ 8'(8'h3C + ch * 8'h11);
    endfunction

    function automatic logic [13:0] pal_addr(input int slot, input int idx, input int lane);
        return {1'b0, 3'(slot), 8'(idx), 2'(lane)};
    endfunction

    function automatic logic [13:0] gam_addr(input int ch, input int idx);
        return {1'b1, 3'b000, 2'(ch), 8'(idx)};
    endfunction

    // expected pixel result for {valid, gamma, slot, index}
    function automatic logic [24:0] exp_pix(input logic [12:0] v);
        logic [7:0] c [3];
        if (!v[12] || v[7:0] == 0) return '0;
        for (int ch = 0; ch < 3; ch++) begin
            c[ch] = (v[10:8] >= 4) ? 8'h00 : pcol(int'(v[10:8]), int'(v[7:0]), ch);
            if (v[11]) c[ch] = gmap(ch, c[ch]);
        end
        return {1'b1, c[2], c[1], c[0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic cpu_write(input logic [13:0] a, input logic [7:0] d);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_check(input string tag, input logic [13:0] a, input logic [7:0] exp);
        cpu_addr = a;
        @(negedge clk);
        check(tag, 32'(cpu_rdata), 32'(exp));
    endtask

    task automatic drive_pix(input logic [12:0] v);
        pix_valid    = v[12];
        mode_ctrl[6] = v[11];
        pix_slot     = v[10:8];
        pix_index    = v[7:0];
    endtask

    task automatic pix_one(input string tag, input logic [12:0] v, input logic [24:0] exp);
        drive_pix(v);
        @(negedge clk);
        drive_pix('0);
        @(negedge clk);
        check(tag, 32'({out_valid, out_rgb}), 32'(exp));
    endtask

    // stimulus table: {valid, gamma, slot[2:0], index[7:0]}
    localparam int NV = 14;
    localparam logic [12:0] VEC [NV] = '{
        {1'b1, 1'b0, 3'd0, 8'd5},
        {1'b1, 1'b0, 3'd1, 8'd200},
        {1'b1, 1'b0, 3'd2, 8'd255},
        {1'b1, 1'b0, 3'd3, 8'd1},
        {1'b1, 1'b0, 3'd0, 8'd0},
        {1'b0, 1'b0, 3'd1, 8'd9},
        {1'b1, 1'b1, 3'd0, 8'd5},
        {1'b1, 1'b1, 3'd3, 8'd77},
        {1'b1, 1'b0, 3'd5, 8'd10},
        {1'b1, 1'b1, 3'd6, 8'd10},
        {1'b1, 1'b1, 3'd2, 8'd0},
        {1'b1, 1'b0, 3'd3, 8'd128},
        {1'b1, 1'b1, 3'd1, 8'd200},
        {1'b1, 1'b0, 3'd7, 8'd3}
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", 32'(out_valid), 0);
        check("R1 out_rgb in reset", 32'(out_rgb), 0);
        check("R1 cpu_rdata in reset", 32'(cpu_rdata), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid after reset", 32'(out_valid), 0);

        // fill palettes (all four lanes) and gamma tables
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 256; i++)
                for (int l = 0; l < 4; l++)
                    cpu_write(pal_addr(b, i, l), pcol(b, i, l));
        for (int ch = 0; ch < 3; ch++)
            for (int i = 0; i < 256; i++)
                cpu_write(gam_addr(ch, i), gmap(ch, 8'(i)));

        // R2: byte lane readback
        cpu_check("R2 blue lane", pal_addr(0, 17, 0), pcol(0, 17, 0));
        cpu_check("R2 green lane", pal_addr(2, 99, 1), pcol(2, 99, 1));
        cpu_check("R2 red lane", pal_addr(3, 255, 2), pcol(3, 255, 2));
        cpu_check("R2 entry 0 stored", pal_addr(1, 0, 0), pcol(1, 0, 0));

        // R7: gamma readback and holes
        cpu_check("R7 gamma blue", gam_addr(0, 40), gmap(0, 8'd40));
        cpu_check("R7 gamma red", gam_addr(2, 255), gmap(2, 8'd255));
        cpu_write(gam_addr(3, 4), 8'hA5);
        cpu_check("R7 gamma channel 3 reads zero", gam_addr(3, 4), 8'h00);
        cpu_write({1'b1, 3'b001, 2'd0, 8'd4}, 8'hA5);
        cpu_check("R7 gamma alias reads zero", {1'b1, 3'b001, 2'd0, 8'd4}, 8'h00);
        cpu_check("R7 gamma blue unchanged", gam_addr(0, 4), gmap(0, 8'd4));

        // R6: unimplemented palettes on the CPU port
        cpu_write(pal_addr(5, 10, 0), 8'h77);
        cpu_check("R6 slot 5 reads zero", pal_addr(5, 10, 0), 8'h00);
        cpu_check("R6 aliased slot 1 unchanged", pal_addr(1, 10, 0), pcol(1, 10, 0));

        // R4 R5 R6 R8: table walk, one pixel per clock
        for (int i = 0; i < NV + 2; i++) begin
            if (i >= 2)
                check($sformatf("R4/R5/R6/R8 vector %0d", i - 2),
                      32'({out_valid, out_rgb}), 32'(exp_pix(VEC[i - 2])));
            drive_pix(i < NV ? VEC[i] : 13'd0);
            @(negedge clk);
        end

        // R3: alpha readback, no effect on colour
        cpu_write(pal_addr(0, 5, 3), 8'hEE);
        cpu_check("R3 alpha readback", pal_addr(0, 5, 3), 8'hEE);
        pix_one("R3 alpha ignored on pixel", {1'b1, 1'b0, 3'd0, 8'd5},
                exp_pix({1'b1, 1'b0, 3'd0, 8'd5}));

        // R5: entry 0 ignored even with gamma on
        pix_one("R5 index 0 with gamma", {1'b1, 1'b1, 3'd3, 8'd0}, 25'd0);

        // R9: write and pixel read of the same entry in one cycle
        drive_pix({1'b1, 1'b0, 3'd1, 8'd33});
        cpu_wr = 1'b1; cpu_addr = pal_addr(1, 33, 2); cpu_wdata = 8'h99;
        @(negedge clk);
        cpu_wr = 1'b0;
        check("R9 cpu read sees old byte", 32'(cpu_rdata), 32'(pcol(1, 33, 2)));
        @(negedge clk);
        drive_pix('0);
        check("R9 colliding pixel old value", 32'({out_valid, out_rgb}),
              32'(exp_pix({1'b1, 1'b0, 3'd1, 8'd33})));
        check("R9 cpu read sees new byte", 32'(cpu_rdata), 32'h99);
        @(negedge clk);
        check("R9 next pixel new value", 32'({out_valid, out_rgb}),
              32'({1'b1, 8'h99, pcol(1, 33, 1), pcol(1, 33, 0)}));
        @(negedge clk);
        check("R5 idle after burst", 32'({out_valid, out_rgb}), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule